// File: doc/BRIEF.md
# Framebuffer Scanout Address Generator

This block turns the active-video strobes of a display timing generator into byte read addresses for a single primary plane. Software programs a framebuffer start address, a line stride and a pixel format code through a small write-only register port. The block then walks the framebuffer. It reloads the start address at each frame start. Within a line it steps the pixel address by the pixel size. At each line end it moves the line start forward by the stride, rounded up to a 16-byte multiple.

Alongside each pixel address the block raises a fetch request when a new 16-byte memory word is needed. It also gives the word-aligned address of that request. A memory front end can then fetch whole words and pick the pixel bytes out of them. Register writes go to staging copies. The stride and format that the walk uses are latched only at frame start, and the start address is loaded into the line pointer at that moment too. A frame in progress therefore never mixes two configurations.

The source size always equals the displayed size. It is up to software to place the plane fully inside the active area.

Top module: `scan_addr_gen`

## Requirements
- R1: After reset every output is low. Pixel strobes that come before the first frame start produce no output.
- R2: A frame start loads the staged start address. The first pixel of the frame is reported at exactly that address.
- R3: Within a line each pixel strobe advances the address by the pixel size, which comes from the format code in bits [31:16] of the layout register. Code 0 gives 1 byte, code 1 gives 2 bytes, and code 2 or any larger code gives 4 bytes.
- R4: A line-end strobe moves the line start by the stride in bits [15:0] of the layout register, rounded up to the next multiple of 16. The next pixel is reported at the new line start.
- R5: Register writes affect the walk only from the next frame start on. A write mid-frame changes neither the following pixel addresses nor the stride of the following lines. A write in the same cycle as a frame start applies to the frame after it.
- R6: A fetch request is raised with a pixel address on the first pixel of every line, and on any pixel whose address has bits [3:0] equal to zero. The fetch address is the pixel address with bits [3:0] cleared.
- R7: A reported address appears exactly one cycle after its pixel strobe. The address-valid output is never high in a cycle that does not follow a strobe.
- R8: A frame start restarts the walk at the start address even in the middle of a line. A pixel strobe in the same cycle as a frame start is dropped.
- R9: A pixel strobe in the same cycle as a line end is reported at the current address. The next pixel is reported at the new line start with a fetch request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 start address, 1 layout (stride [15:0], format [31:16]) |
| cfg_wdata | input | AW | Register write data |
| frame_start | input | 1 | Start-of-frame strobe from the timing generator |
| pix_valid | input | 1 | Active-pixel strobe |
| line_end | input | 1 | End-of-active-line strobe |
| pix_addr_valid | output | 1 | Pixel address valid |
| pix_addr | output | AW | Byte address of the pixel |
| fetch_req | output | 1 | A new 16-byte word must be fetched |
| fetch_addr | output | AW | 16-byte-aligned address of the word to fetch |

The walk runs through three named states. IDLE means no frame has started yet. LINE_WAIT means a line is pending and its first pixel has not come. IN_LINE means the line has begun. Frame start moves any state to LINE_WAIT. A pixel in LINE_WAIT without a line end moves to IN_LINE. A line end in IN_LINE moves back to LINE_WAIT.

## Verification
The hardest situations to reach are the ones where strobes from the timing generator coincide. These are a frame start together with a pixel, a pixel together with a line end, and a register write in the same cycle as the frame start that latches the shadow copies. Normal raster traffic never produces them, so the directed tests drive those strobes together in single cycles. They then follow each one with ordinary pixels, whose addresses show which configuration and which line start the walk took up.

// File: rtl/scan_pkg.sv
package scan_pkg;
    localparam int WORD_BYTES = 16;
    localparam int WORD_LSB   = $clog2(WORD_BYTES);

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_LINE_WAIT = 2'd1,
        ST_IN_LINE   = 2'd2
    } scan_state_e;
endpackage

// File: rtl/scan_fmt_decode.sv
module scan_fmt_decode #(
    parameter int FW = 16
) (
    input  logic [FW-1:0] fmt_code,
    output logic [2:0]    pix_bytes
);
    always_comb begin
        if (fmt_code == '0)
            pix_bytes = 3'd1;
        else if (fmt_code == FW'(1))
            pix_bytes = 3'd2;
        else
            pix_bytes = 3'd4;
    end
endmodule

// File: rtl/scan_regs.sv
module scan_regs #(
    parameter int AW = 32,
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic          cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    input  logic          latch,
    output logic [AW-1:0] stg_base,
    output logic [SW:0]   sh_stride,
    output logic [2:0]    sh_step
);
    import scan_pkg::*;
    localparam int FW = AW - SW;

    logic [SW-1:0] stg_stride;
    logic [FW-1:0] stg_fmt;
    logic [2:0]    stg_step;
    logic [SW:0]   stg_stride_pad;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_base   <= '0;
            stg_stride <= '0;
            stg_fmt    <= '0;
        end else if (cfg_we) begin
            if (cfg_sel) begin
                stg_stride <= cfg_wdata[SW-1:0];
                stg_fmt    <= cfg_wdata[AW-1:SW];
            end else begin
                stg_base <= cfg_wdata;
            end
        end
    end

    scan_fmt_decode #(.FW(FW)) dec_i (
        .fmt_code  (stg_fmt),
        .pix_bytes (stg_step)
    );

    always_comb begin
        stg_stride_pad = ({1'b0, stg_stride} + (SW+1)'(WORD_BYTES - 1));
        stg_stride_pad[WORD_LSB-1:0] = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_stride <= '0;
            sh_step   <= 3'd1;
        end else if (latch) begin
            sh_stride <= stg_stride_pad;
            sh_step   <= stg_step;
        end
    end
endmodule

// File: rtl/scan_stepper.sv
module scan_stepper #(
    parameter int AW = 32,
    parameter int SW = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  frame_start,
    input  logic                  pix_valid,
    input  logic                  line_end,
    input  logic [AW-1:0]         stg_base,
    input  logic [SW:0]           sh_stride,
    input  logic [2:0]            sh_step,
    output scan_pkg::scan_state_e cur_state,
    output logic                  pix_addr_valid,
    output logic [AW-1:0]         pix_addr,
    output logic                  fetch_req,
    output logic [AW-1:0]         fetch_addr
);
    import scan_pkg::*;

    scan_state_e   state_q, state_d;
    logic [AW-1:0] line_q;
    logic [AW-1:0] ptr_q;
    logic [AW-1:0] next_line;
    logic          take_pix;
    logic          word_edge;

    assign cur_state = state_q;
    assign next_line = line_q + AW'(sh_stride);
    assign take_pix  = pix_valid && !frame_start && (state_q != ST_IDLE);
    assign word_edge = (ptr_q[WORD_LSB-1:0] == '0);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (frame_start) state_d = ST_LINE_WAIT;
            end
            ST_LINE_WAIT: begin
                if (frame_start)                 state_d = ST_LINE_WAIT;
                else if (pix_valid && !line_end) state_d = ST_IN_LINE;
            end
            ST_IN_LINE: begin
                if (frame_start)   state_d = ST_LINE_WAIT;
                else if (line_end) state_d = ST_LINE_WAIT;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= '0;
            ptr_q  <= '0;
        end else if (frame_start) begin
            line_q <= stg_base;
            ptr_q  <= stg_base;
        end else if (state_q != ST_IDLE) begin
            if (line_end) begin
                line_q <= next_line;
                ptr_q  <= next_line;
            end else if (pix_valid) begin
                ptr_q <= ptr_q + AW'(sh_step);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_addr_valid <= 1'b0;
            pix_addr       <= '0;
            fetch_req      <= 1'b0;
            fetch_addr     <= '0;
        end else begin
            pix_addr_valid <= take_pix;
            fetch_req      <= take_pix && ((state_q == ST_LINE_WAIT) || word_edge);
            if (take_pix) begin
                pix_addr   <= ptr_q;
                fetch_addr <= {ptr_q[AW-1:WORD_LSB], {WORD_LSB{1'b0}}};
            end
        end
    end
endmodule

// File: rtl/scan_addr_gen.sv
module scan_addr_gen #(
    parameter int AW = 32,
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic          cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    input  logic          frame_start,
    input  logic          pix_valid,
    input  logic          line_end,
    output logic          pix_addr_valid,
    output logic [AW-1:0] pix_addr,
    output logic          fetch_req,
    output logic [AW-1:0] fetch_addr
);
    import scan_pkg::*;

    logic [AW-1:0] stg_base;
    logic [SW:0]   sh_stride;
    logic [2:0]    sh_step;
    scan_state_e   cur_state;

    scan_regs #(.AW(AW), .SW(SW)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .latch     (frame_start),
        .stg_base  (stg_base),
        .sh_stride (sh_stride),
        .sh_step   (sh_step)
    );

    scan_stepper #(.AW(AW), .SW(SW)) step_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .frame_start    (frame_start),
        .pix_valid      (pix_valid),
        .line_end       (line_end),
        .stg_base       (stg_base),
        .sh_stride      (sh_stride),
        .sh_step        (sh_step),
        .cur_state      (cur_state),
        .pix_addr_valid (pix_addr_valid),
        .pix_addr       (pix_addr),
        .fetch_req      (fetch_req),
        .fetch_addr     (fetch_addr)
    );
endmodule

// File: rtl/scan_addr_gen_chk.sv
module scan_addr_gen_chk #(
    parameter int AW = 32,
    parameter int SW = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  frame_start,
    input logic                  pix_valid,
    input logic                  pix_addr_valid,
    input logic                  fetch_req,
    input logic [AW-1:0]         pix_addr,
    input scan_pkg::scan_state_e cur_state,
    input logic [SW:0]           sh_stride,
    input logic [2:0]            sh_step
);
    import scan_pkg::*;

    AST_NO_STRAY_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        pix_addr_valid |-> $past(pix_valid)); // R7
    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == ST_IDLE) |=> !pix_addr_valid); // R1
    AST_FRAME_DROPS_PIXEL: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !pix_addr_valid); // R8
    AST_WORD_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_addr_valid && (pix_addr[WORD_LSB-1:0] == '0)) |-> fetch_req); // R6
    AST_FETCH_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |-> pix_addr_valid); // R6
    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> ($stable(sh_stride) && $stable(sh_step))); // R5
endmodule

bind scan_addr_gen scan_addr_gen_chk #(.AW(AW), .SW(SW)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .frame_start    (frame_start),
    .pix_valid      (pix_valid),
    .pix_addr_valid (pix_addr_valid),
    .fetch_req      (fetch_req),
    .pix_addr       (pix_addr),
    .cur_state      (cur_state),
    .sh_stride      (sh_stride),
    .sh_step        (sh_step)
);

// File: tb/scan_addr_gen_tb_top.sv
`timescale 1ns/1ps
module scan_addr_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        frame_start = 1'b0;
    logic        pix_valid = 1'b0;
    logic        line_end = 1'b0;
    logic        pix_addr_valid;
    logic [31:0] pix_addr;
    logic        fetch_req;
    logic [31:0] fetch_addr;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    scan_addr_gen dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .frame_start(frame_start), .pix_valid(pix_valid),
        .line_end(line_end), .pix_addr_valid(pix_addr_valid), .pix_addr(pix_addr),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr)
    );

    typedef struct packed {
        logic [31:0] base;
        logic [15:0] stride;
        logic [15:0] fmt;
        logic [7:0]  npix;
        logic [7:0]  nlines;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VEC [NV] = '{
        '{32'h0000_1000, 16'd100, 16'd0,      8'd20, 8'd3},
        '{32'h0000_2008, 16'd64,  16'd1,      8'd12, 8'd3},
        '{32'h0003_0000, 16'd17,  16'd2,      8'd9,  8'd3},
        '{32'h0000_07F0, 16'd1,   16'd3,      8'd5,  8'd2},
        '{32'h0001_0004, 16'd48,  16'h0100,   8'd6,  8'd2}
    };

    function automatic logic [31:0] pad16(input logic [15:0] s);
        return ((32'(s) + 32'd15) / 32'd16) * 32'd16;
    endfunction

    function automatic logic [31:0] psize(input logic [15:0] f);
        if (f == 16'd0) return 32'd1;
        if (f == 16'd1) return 32'd2;
        return 32'd4;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic fs, input logic pv, input logic le);
        @(negedge clk);
        frame_start = fs; pix_valid = pv; line_end = le;
        @(negedge clk);
        frame_start = 1'b0; pix_valid = 1'b0; line_end = 1'b0;
    endtask

    task automatic wr(input logic sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic px(input string tag, input logic le, input logic [31:0] ea, input logic ef);
        cyc(1'b0, 1'b1, le);
        chk({tag, " valid"}, 32'(pix_addr_valid), 32'd1);
        chk({tag, " addr"}, pix_addr, ea);
        chk({tag, " fetch R6"}, 32'(fetch_req), 32'(ef));
        if (ef) chk({tag, " fetch_addr R6"}, fetch_addr, {ea[31:4], 4'h0});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] a;
        repeat (4) @(negedge clk);
        chk("R1 reset valid", 32'(pix_addr_valid), 32'd0);
        chk("R1 reset fetch", 32'(fetch_req), 32'd0);
        chk("R1 reset addr", pix_addr, 32'd0);
        rst_n = 1'b1;
        wr(1'b0, 32'h0000_4000);
        cyc(1'b0, 1'b1, 1'b0);
        chk("R1 pixel before frame", 32'(pix_addr_valid), 32'd0);

        // table walk: R2 R3 R4 R6
        for (int v = 0; v < NV; v++) begin
            wr(1'b0, VEC[v].base);
            wr(1'b1, {VEC[v].fmt, VEC[v].stride});
            cyc(1'b1, 1'b0, 1'b0);
            for (int l = 0; l < int'(VEC[v].nlines); l++) begin
                for (int i = 0; i < int'(VEC[v].npix); i++) begin
                    a = VEC[v].base + 32'(l) * pad16(VEC[v].stride) + 32'(i) * psize(VEC[v].fmt);
                    px($sformatf("R3 R4 vec%0d l%0d p%0d", v, l, i), 1'b0, a, (i == 0) || (a[3:0] == 4'h0));
                end
                cyc(1'b0, 1'b0, 1'b1);
            end
        end

        // R5 mid-frame write has no effect until the next frame
        wr(1'b0, 32'h0000_8000);
        wr(1'b1, {16'd2, 16'd32});
        cyc(1'b1, 1'b0, 1'b0);
        px("R2 first pixel", 1'b0, 32'h0000_8000, 1'b1);
        wr(1'b0, 32'h0000_9000);
        wr(1'b1, {16'd0, 16'd64});
        px("R5 mid-frame step", 1'b0, 32'h0000_8004, 1'b0);
        cyc(1'b0, 1'b0, 1'b1);
        px("R5 old stride", 1'b0, 32'h0000_8020, 1'b1);
        cyc(1'b0, 1'b0, 0);
        chk("R7 no output without strobe", 32'(pix_addr_valid), 32'd0);
        cyc(1'b1, 1'b0, 1'b0);
        px("R5 new base", 1'b0, 32'h0000_9000, 1'b1);
        px("R5 new step", 1'b0, 32'h0000_9001, 1'b0);
        cyc(1'b0, 1'b0, 1'b1);
        px("R5 new stride", 1'b0, 32'h0000_9040, 1'b1);

        // R5 write in the same cycle as frame start
        wr(1'b1, {16'd2, 16'd64});
        cyc(1'b1, 1'b0, 1'b0);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = 32'h0000_5000; frame_start = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0; frame_start = 1'b0;
        px("R5 write with frame start", 1'b0, 32'h0000_9000, 1'b1);

        // R8 frame start mid-line with a pixel strobe
        cyc(1'b1, 1'b1, 1'b0);
        chk("R8 pixel dropped", 32'(pix_addr_valid), 32'd0);
        px("R8 restart at base", 1'b0, 32'h0000_5000, 1'b1);

        // R9 pixel together with line end
        px("R9 pixel on line end", 1'b1, 32'h0000_5004, 1'b0);
        px("R9 next line start", 1'b0, 32'h0000_5040, 1'b1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule